// File: doc/BRIEF.md
# Prescaled Countdown Timer Channel

This block is a single down-counting timer channel behind a small register port. Three tick sources arrive as single-cycle enable pulses in the block's clock domain: a low-speed tick, a fast oscillator tick and an alternate tick. The channel detects a rising edge on each source, selects one of them, and passes it through a power-of-two prescaler with a ratio from 1 to 128. Each prescaled tick decrements a 32-bit current value while the channel is enabled.

When a counting tick finds the current value at 1 or 0, a zero event occurs. The zero event sets the channel's pending flag. In periodic mode the current value then restarts from the 32-bit interval register. In single-shot mode the current value parks at 0 and the enable bit clears itself. The interrupt output is the pending flag gated by the channel's interrupt-enable bit. Software writes 1 to clear the pending flag. A self-clearing reload request copies the interval into the current value.

There is no streaming data path. Every pin is a plain control or status signal, and register writes take effect in the cycle they are presented.

Top module: `tick_down_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: The current value changes only through a reload or a counting tick, and a counting tick needs control bit 0 (enable) set. Otherwise the value holds. A counting tick with a current value above 1 decrements it by exactly one.
- R3: Writing control with bit 1 set copies the interval into the current value on the next clock edge. Bit 1 then reads back 0. A reload takes priority over a counting tick in the same cycle.
- R4: Control bits 3:2 select the tick source: 0 is `tick_slow`, 1 is `tick_fast`, 2 is `tick_alt`, and 3 selects no source. Only a rising edge of the selected input counts, so a level held high for several cycles gives one tick. That tick reaches the prescaler one cycle after the input rises.
- R5: With control bits 6:4 equal to n, the prescaler passes one tick for every 2^n selected source edges.
- R6: A control write that changes bits 6:2 restarts the prescaler count from zero. A source edge in that same cycle is discarded.
- R7: A counting tick while the current value is 1 or 0 is a zero event, and it sets the pending flag.
- R8: With control bit 7 clear (periodic), a zero event loads the interval into the current value and counting continues.
- R9: With control bit 7 set (single-shot), a zero event leaves the current value at 0 and clears control bit 0.
- R10: The pending flag is at bit CH_IDX of the status register (address 4). Writing 1 there clears it, and writing 0 has no effect. A zero event in the same cycle wins over the clear.
- R11: `irq` is high exactly when the pending flag and bit CH_IDX of the interrupt-enable register (address 3) are both set.
- R12: Address map: 0 control (bits 7:0), 1 interval, 2 current value (read-only; writes are ignored), 3 interrupt enable, 4 status. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_slow | input | 1 | Low-speed tick pulse, source code 0 |
| tick_fast | input | 1 | Fast oscillator tick pulse, source code 1 |
| tick_alt | input | 1 | Alternate tick pulse, source code 2 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| irq | output | 1 | Gated interrupt request |

## Verification
A prescaler phase that has slipped does not show at once. It appears as a current value that decrements one selected edge early or late, which can be up to 127 edges after the fault. The comparison of the current value on every cycle catches it at the first misplaced step. A wrong zero-event decision shows on the next edge in two places: in `irq` once interrupts are enabled, and in the current value, which then fails to restart or fails to park. A stuck reload or enable bit shows within one cycle in the control readback.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_W = 8;
  localparam int SRC_W  = 2;
  localparam int PRE_W  = 3;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_INTV = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CUR  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_IEN  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd4;

  typedef struct packed {
    logic             single;  // bit 7
    logic [PRE_W-1:0] pre;     // bits 6:4
    logic [SRC_W-1:0] src;     // bits 3:2
    logic             reload;  // bit 1
    logic             run;     // bit 0
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
  parameter int N_SRC = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] tick_in,
  input  logic [SEL_W-1:0] sel,
  output logic             tick_out
);
  logic [N_SRC-1:0] level_q;
  logic [N_SRC-1:0] rise_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        level_q[g] <= 1'b0;
        rise_q[g]  <= 1'b0;
      end else begin
        level_q[g] <= tick_in[g];
        rise_q[g]  <= tick_in[g] & ~level_q[g];
      end
    end
  end

  always_comb begin
    tick_out = 1'b0;
    for (int i = 0; i < N_SRC; i++)
      if (sel == SEL_W'(i)) tick_out = rise_q[i];
  end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              tick_out
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit    = {CNT_W{1'b1}} >> (CNT_W - int'(code));
  assign tick_out = tick_in && !restart && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (tick_in) cnt_q <= tick_out ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_down_core.sv
module tmr_down_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic              step,
  input  logic              single,
  input  logic [DATA_W-1:0] interval,
  output logic [DATA_W-1:0] value,
  output logic              zero_evt
);
  logic at_end;

  assign at_end   = (value <= DATA_W'(1));
  assign zero_evt = step && !reload && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        value <= '0;
    else if (reload)   value <= interval;
    else if (step) begin
      if (!at_end)     value <= value - 1'b1;
      else if (single) value <= '0;
      else             value <= interval;
    end
  end
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CH_IDX = 0,
  parameter int N_SRC  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_slow,
  input  logic              tick_fast,
  input  logic              tick_alt,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  tmr_ctrl_t         ctrl_q;
  tmr_ctrl_t         ctrl_w;
  logic [DATA_W-1:0] intv_q;
  logic [DATA_W-1:0] cur_q;
  logic              ien_q;
  logic              pend_q;
  logic              wr_ctrl, wr_intv, wr_ien, wr_stat;
  logic              restart, src_tick, cnt_tick, zero_evt;

  assign ctrl_w  = tmr_ctrl_t'(reg_wdata[CTRL_W-1:0]);
  assign wr_ctrl = reg_wr && (reg_addr == ADR_CTRL);
  assign wr_intv = reg_wr && (reg_addr == ADR_INTV);
  assign wr_ien  = reg_wr && (reg_addr == ADR_IEN);
  assign wr_stat = reg_wr && (reg_addr == ADR_STAT);
  assign restart = wr_ctrl && ({ctrl_w.pre, ctrl_w.src} != {ctrl_q.pre, ctrl_q.src});

  tmr_tick_sel #(.N_SRC(N_SRC), .SEL_W(SRC_W)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .tick_in({tick_alt, tick_fast, tick_slow}),
    .sel(ctrl_q.src), .tick_out(src_tick)
  );

  tmr_prescale #(.CODE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_in(src_tick), .restart(restart),
    .code(ctrl_q.pre), .tick_out(cnt_tick)
  );

  tmr_down_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .reload(ctrl_q.reload),
    .step(cnt_tick && ctrl_q.run), .single(ctrl_q.single),
    .interval(intv_q), .value(cur_q), .zero_evt(zero_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_w;
    end else begin
      if (ctrl_q.reload)             ctrl_q.reload <= 1'b0;
      if (zero_evt && ctrl_q.single) ctrl_q.run    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intv_q <= '0;
      ien_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_intv) intv_q <= reg_wdata;
      if (wr_ien)  ien_q  <= reg_wdata[CH_IDX];
      if (zero_evt)                          pend_q <= 1'b1;
      else if (wr_stat && reg_wdata[CH_IDX]) pend_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
      ADR_INTV: reg_rdata = intv_q;
      ADR_CUR:  reg_rdata = cur_q;
      ADR_IEN:  reg_rdata[CH_IDX] = ien_q;
      ADR_STAT: reg_rdata[CH_IDX] = pend_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = pend_q & ien_q;
endmodule

// File: rtl/tick_down_timer_chk.sv
module tick_down_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              reload,
  input logic              single,
  input logic              wr_ctrl,
  input logic              cnt_tick,
  input logic              pend,
  input logic [DATA_W-1:0] cur,
  input logic [DATA_W-1:0] intv
);
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reload) |=> $stable(cur)); // R2

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && run && !reload && cur > DATA_W'(1)) |=> (cur == $past(cur) - 1'b1)); // R2

  AST_RELOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !wr_ctrl) |=> (cur == $past(intv) && !reload)); // R3

  AST_ZERO_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && run && !reload && cur <= DATA_W'(1)) |=> pend); // R7

  AST_PERIODIC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && run && !reload && !single && cur <= DATA_W'(1)) |=> (cur == $past(intv))); // R8

  AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && run && !reload && single && !wr_ctrl && cur <= DATA_W'(1)) |=> (cur == '0 && !run)); // R9
endmodule

bind tick_down_timer tick_down_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .reload(ctrl_q.reload),
  .single(ctrl_q.single), .wr_ctrl(wr_ctrl), .cnt_tick(cnt_tick),
  .pend(pend_q), .cur(cur_q), .intv(intv_q)
);

// File: tb/sim_tick_down_timer.sv
module sim_tick_down_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  tk = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd2;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  string phase = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_down_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_slow(tk[0]), .tick_fast(tk[1]), .tick_alt(tk[2]),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // behavioural reference state
  bit        m_run = 0, m_rel = 0, m_single = 0, m_pend = 0, m_ien = 0;
  bit [1:0]  m_src = 0;
  bit [2:0]  m_pre = 0;
  bit [31:0] m_intv = 0, m_cur = 0;
  int        m_pc = 0;
  bit [2:0]  m_prev = 0, m_edge = 0;

  function automatic bit [31:0] model_rd(input bit [2:0] a);
    case (a)
      3'd0: return {24'd0, m_single, m_pre, m_src, m_rel, m_run};
      3'd1: return m_intv;
      3'd2: return m_cur;
      3'd3: return 32'(m_ien) << CH;
      3'd4: return 32'(m_pend) << CH;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_rel = 0; m_single = 0; m_pend = 0; m_ien = 0;
      m_src = 0; m_pre = 0; m_intv = 0; m_cur = 0; m_pc = 0; m_prev = 0; m_edge = 0;
    end else begin
      bit src_ev, rst_pc, hit, zero;
      bit [31:0] old_intv;
      old_intv = m_intv;
      src_ev = (m_src < 3) ? m_edge[m_src] : 1'b0;
      rst_pc = reg_wr && reg_addr == 3'd0 && (reg_wdata[6:2] != {m_pre, m_src});
      hit = src_ev && !rst_pc && (m_pc == (1 << m_pre) - 1);
      if (rst_pc) m_pc = 0;
      else if (src_ev) m_pc = hit ? 0 : m_pc + 1;
      zero = 0;
      if (m_rel) begin
        m_cur = old_intv;
      end else if (hit && m_run) begin
        if (m_cur > 1) m_cur = m_cur - 1;
        else begin
          zero = 1;
          m_cur = m_single ? 32'd0 : old_intv;
        end
      end
      if (reg_wr && reg_addr == 3'd0) begin
        {m_single, m_pre, m_src, m_rel, m_run} = reg_wdata[7:0];
      end else begin
        m_rel = 0;
        if (zero && m_single) m_run = 0;
      end
      if (reg_wr && reg_addr == 3'd1) m_intv = reg_wdata;
      if (reg_wr && reg_addr == 3'd3) m_ien = reg_wdata[CH];
      if (zero) m_pend = 1;
      else if (reg_wr && reg_addr == 3'd4 && reg_wdata[CH]) m_pend = 0;
      m_edge = tk & ~m_prev;
      m_prev = tk;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit [31:0] exp_rd;
      exp_rd = model_rd(reg_addr);
      n_checks++;
      if (reg_rdata !== exp_rd) begin
        n_fail++;
        $display("FAIL %s addr=%0d rdata actual=%h expected=%h", phase, reg_addr, reg_rdata, exp_rd);
      end
      n_checks++;
      if (irq !== (m_pend & m_ien)) begin
        n_fail++;
        $display("FAIL %s irq actual=%b expected=%b", phase, irq, m_pend & m_ien);
      end
    end
  end

  function automatic bit [31:0] ctl(bit run, bit rel, bit [1:0] src, bit [2:0] pre, bit single);
    return {24'd0, single, pre, src, rel, run};
  endfunction

  task automatic wr(input bit [2:0] a, input bit [31:0] d);
    @(negedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 0; reg_addr = 3'd2;
  endtask

  task automatic rd(input bit [2:0] a);
    @(negedge clk); #1;
    reg_addr = a;
    @(negedge clk); #1;
    reg_addr = 3'd2;
  endtask

  task automatic tick(input int idx, input int hold);
    @(negedge clk); #1;
    tk[idx] = 1'b1;
    repeat (hold) @(negedge clk);
    #1 tk[idx] = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int idx, input int n);
    for (int i = 0; i < n; i++) tick(idx, 1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired in phase %s", phase);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    phase = "R1";
    for (int a = 0; a < 8; a++) rd(3'(a));

    phase = "R12";
    wr(3'd1, 32'd5);
    wr(3'd2, 32'h99);
    rd(3'd1); rd(3'd5); rd(3'd6); rd(3'd7);

    phase = "R3";
    wr(3'd0, ctl(0, 1, 1, 0, 0));
    rd(3'd0); rd(3'd0);

    phase = "R2";
    ticks(1, 3);

    phase = "R4";
    wr(3'd0, ctl(1, 0, 1, 0, 0));
    tick(1, 4);
    ticks(0, 2);
    ticks(2, 2);
    wr(3'd0, ctl(1, 0, 0, 0, 0));
    ticks(0, 1);
    ticks(1, 2);
    wr(3'd0, ctl(1, 0, 2, 0, 0));
    ticks(2, 1);
    wr(3'd0, ctl(1, 0, 3, 0, 0));
    ticks(0, 1); ticks(1, 1); ticks(2, 1);

    phase = "R8";
    wr(3'd0, ctl(1, 0, 1, 0, 0));
    ticks(1, 7);
    rd(3'd4);

    phase = "R11";
    rd(3'd4);
    wr(3'd3, 32'd1 << CH);
    rd(3'd3);

    phase = "R10";
    wr(3'd4, 32'd0);
    rd(3'd4);
    wr(3'd4, 32'd1 << CH);
    rd(3'd4);

    phase = "R7";
    wr(3'd0, ctl(1, 1, 1, 0, 0));
    ticks(1, 5);
    rd(3'd4);

    phase = "R10";
    wr(3'd4, 32'd1 << CH);
    ticks(1, 4);
    @(negedge clk); #1 tk[1] = 1'b1;
    @(negedge clk); #1 tk[1] = 1'b0;
    reg_wr = 1; reg_addr = 3'd4; reg_wdata = 32'd1 << CH;
    @(negedge clk); #1 reg_wr = 0; reg_addr = 3'd4;
    @(negedge clk); #1 reg_addr = 3'd2;

    phase = "R5";
    wr(3'd1, 32'd40);
    wr(3'd0, ctl(1, 1, 1, 2, 0));
    ticks(1, 9);
    wr(3'd0, ctl(1, 0, 1, 7, 0));
    ticks(1, 130);

    phase = "R6";
    wr(3'd0, ctl(1, 0, 1, 3, 0));
    ticks(1, 5);
    wr(3'd0, ctl(1, 0, 1, 2, 0));
    ticks(1, 5);
    wr(3'd0, ctl(1, 0, 1, 2, 0));
    ticks(1, 3);
    @(negedge clk); #1 tk[1] = 1'b1;
    @(negedge clk); #1 tk[1] = 1'b0;
    reg_wr = 1; reg_addr = 3'd0; reg_wdata = ctl(1, 0, 1, 1, 0);
    @(negedge clk); #1 reg_wr = 0;
    ticks(1, 4);

    phase = "R9";
    wr(3'd1, 32'd3);
    wr(3'd0, ctl(1, 1, 2, 0, 1));
    ticks(2, 6);
    rd(3'd0);
    rd(3'd4);

    phase = "R3";
    wr(3'd1, 32'd9);
    wr(3'd0, ctl(1, 1, 2, 0, 0));
    ticks(2, 2);
    rd(3'd0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule